// File: doc/BRIEF.md
# PWM Frequency-to-Divider Solver

This block turns a requested PWM output frequency, given as an integer number of hertz, into the settings for a PWM counter that runs from a fixed system clock. It picks the smallest integer clock prescaler for which the counter period still fits a 16-bit wrap register. This keeps the duty resolution as fine as possible. It also computes the wrap value and the frequency that those two settings actually produce after quantisation. Requests that cannot be met return an error flag.

A request enters on a valid/ready stream. `in_ready` is high only while the solver is idle, and a request is taken on a clock edge where both `in_valid` and `in_ready` are high. The answer leaves on a second valid/ready stream. `out_valid` stays high, and every result field stays unchanged, until `out_ready` is seen high on a clock edge. No new request is accepted while a result is pending, so back-pressure on the output stalls the input.

The work runs as three passes through one shared shift-and-subtract divider. The latency therefore has a fixed upper bound that depends only on the datapath width.

Top module: `pwm_freq_solver`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `out_err` is 0, and `out_div`, `out_wrap` and `out_freq` are 0.
- R2: A request of 0 Hz produces a result with `out_err` = 1.
- R3: A request above `MAX_FREQ_HZ` (default 62 500 000) produces `out_err` = 1. A request equal to `MAX_FREQ_HZ` is accepted.
- R4: The prescaler is ceil(CLK_HZ / (f × 2^WRAP_W)), raised to 1 if that gives 0. If the prescaler exceeds 2^DIV_W − 1 (255), `out_err` = 1. With the defaults, 7 Hz fails and 8 Hz gives 239.
- R5: `out_wrap` = P − 1, where the period P is CLK_HZ / (prescaler × f) rounded to nearest, with exact halves rounded up.
- R6: `out_freq` = floor(CLK_HZ / (prescaler × P)).
- R7: A period P below 2 (a wrap value below 1) produces `out_err` = 1.
- R8: When a result reports `out_err` = 1, `out_div`, `out_wrap` and `out_freq` keep the values of the last successful result.
- R9: `in_ready` and `out_valid` are never high together. While `out_valid` = 1 and `out_ready` = 0, `out_valid` and all result fields hold steady.
- R10: `out_valid` rises no more than 3 × (DW + 4) + 4 cycles after a request is accepted, where DW = FREQ_W + WRAP_W + 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Solver idle and able to take a request |
| in_freq | input | FREQ_W | Requested frequency in Hz |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_err | output | 1 | Request was invalid or unreachable |
| out_div | output | DIV_W | Clock prescaler |
| out_wrap | output | WRAP_W | Counter wrap value (period − 1) |
| out_freq | output | FREQ_W | Frequency actually achieved, in Hz |

## Verification
The main instance is built with the default parameters: a 125 MHz clock, an 8-bit prescaler, a 16-bit wrap and a 62.5 MHz ceiling. These settings exercise the rejection of zero, over-ceiling and too-low requests. They also cover the boundary between prescaler 1 and 2, and the rounding of the period. A second instance raises `MAX_FREQ_HZ` to the clock rate. That makes the period-below-two error path reachable, which the default ceiling masks.

// File: rtl/pwm_solver_pkg.sv
package pwm_solver_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIVSEL,
    ST_PERIOD,
    ST_ACTUAL,
    ST_RESP
  } solve_state_t;
endpackage

// File: rtl/pwm_iter_div.sv
module pwm_iter_div #(
  parameter int W = 50
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [W:0]    trial;
  logic          ge;

  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    ge    = (trial >= {1'b0, den_q});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= num;
        den_q <= den;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        rem_q <= ge ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
        quo_q <= {quo_q[W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) done_q <= 1'b1;
      end
    end
  end

  assign done = done_q;
  assign quo  = quo_q;
  assign rem  = rem_q;
endmodule

// File: rtl/pwm_solver_ctrl.sv
module pwm_solver_ctrl
  import pwm_solver_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned MAX_FREQ_HZ = 62_500_000,
  parameter int          FREQ_W      = 32,
  parameter int          DIV_W       = 8,
  parameter int          WRAP_W      = 16,
  parameter int          DW          = FREQ_W + WRAP_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FREQ_W-1:0] in_freq,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_err,
  output logic [DIV_W-1:0]  out_div,
  output logic [WRAP_W-1:0] out_wrap,
  output logic [FREQ_W-1:0] out_freq,
  output logic              d_start,
  output logic [DW-1:0]     d_num,
  output logic [DW-1:0]     d_den,
  input  logic              d_done,
  input  logic [DW-1:0]     d_quo,
  input  logic [DW-1:0]     d_rem
);
  localparam logic [DW-1:0]     CLK_V   = DW'(CLK_HZ);
  localparam logic [FREQ_W-1:0] MAX_V   = FREQ_W'(MAX_FREQ_HZ);
  localparam logic [DW:0]       DIV_MAX = (DW+1)'((1 << DIV_W) - 1);

  solve_state_t      state_q;
  logic [FREQ_W-1:0] freq_q;
  logic [DIV_W-1:0]  psc_q;
  logic [WRAP_W-1:0] wrap_q;
  logic              err_q;
  logic [DIV_W-1:0]  res_div_q;
  logic [WRAP_W-1:0] res_wrap_q;
  logic [FREQ_W-1:0] res_freq_q;
  logic              start_q;
  logic [DW-1:0]     num_q, den_q;

  logic [DW:0]   cand, cand_c;
  logic          cand_ok;
  logic [DW-1:0] prod;

  always_comb begin
    cand    = {1'b0, d_quo} + (DW+1)'(|d_rem);
    cand_c  = (cand == '0) ? (DW+1)'(1) : cand;
    cand_ok = (cand_c <= DIV_MAX);
    prod    = DW'(cand_c[DIV_W-1:0]) * DW'(freq_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      freq_q     <= '0;
      psc_q      <= '0;
      wrap_q     <= '0;
      err_q      <= 1'b0;
      res_div_q  <= '0;
      res_wrap_q <= '0;
      res_freq_q <= '0;
      start_q    <= 1'b0;
      num_q      <= '0;
      den_q      <= '0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (in_valid) begin
          freq_q <= in_freq;
          if (in_freq == '0 || in_freq > MAX_V) begin
            err_q   <= 1'b1;
            state_q <= ST_RESP;
          end else begin
            start_q <= 1'b1;
            num_q   <= CLK_V;
            den_q   <= DW'(in_freq) << WRAP_W;
            state_q <= ST_DIVSEL;
          end
        end
        ST_DIVSEL: if (d_done) begin
          if (!cand_ok) begin
            err_q   <= 1'b1;
            state_q <= ST_RESP;
          end else begin
            psc_q   <= cand_c[DIV_W-1:0];
            start_q <= 1'b1;
            num_q   <= (CLK_V << 1) + prod;
            den_q   <= prod << 1;
            state_q <= ST_PERIOD;
          end
        end
        ST_PERIOD: if (d_done) begin
          if (d_quo < DW'(2)) begin
            err_q   <= 1'b1;
            state_q <= ST_RESP;
          end else begin
            wrap_q  <= WRAP_W'(d_quo - DW'(1));
            start_q <= 1'b1;
            num_q   <= CLK_V;
            den_q   <= DW'(psc_q) * d_quo;
            state_q <= ST_ACTUAL;
          end
        end
        ST_ACTUAL: if (d_done) begin
          res_div_q  <= psc_q;
          res_wrap_q <= wrap_q;
          res_freq_q <= FREQ_W'(d_quo);
          err_q      <= 1'b0;
          state_q    <= ST_RESP;
        end
        ST_RESP: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_RESP);
  assign out_err   = err_q;
  assign out_div   = res_div_q;
  assign out_wrap  = res_wrap_q;
  assign out_freq  = res_freq_q;
  assign d_start   = start_q;
  assign d_num     = num_q;
  assign d_den     = den_q;
endmodule

// File: rtl/pwm_freq_solver.sv
module pwm_freq_solver #(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned MAX_FREQ_HZ = 62_500_000,
  parameter int          FREQ_W      = 32,
  parameter int          DIV_W       = 8,
  parameter int          WRAP_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FREQ_W-1:0] in_freq,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_err,
  output logic [DIV_W-1:0]  out_div,
  output logic [WRAP_W-1:0] out_wrap,
  output logic [FREQ_W-1:0] out_freq
);
  localparam int DW = FREQ_W + WRAP_W + 2;

  logic          d_start, d_done;
  logic [DW-1:0] d_num, d_den, d_quo, d_rem;

  pwm_solver_ctrl #(
    .CLK_HZ(CLK_HZ), .MAX_FREQ_HZ(MAX_FREQ_HZ), .FREQ_W(FREQ_W),
    .DIV_W(DIV_W), .WRAP_W(WRAP_W), .DW(DW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_freq(in_freq),
    .out_valid(out_valid), .out_ready(out_ready), .out_err(out_err),
    .out_div(out_div), .out_wrap(out_wrap), .out_freq(out_freq),
    .d_start(d_start), .d_num(d_num), .d_den(d_den),
    .d_done(d_done), .d_quo(d_quo), .d_rem(d_rem)
  );

  pwm_iter_div #(.W(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(d_start), .num(d_num), .den(d_den),
    .done(d_done), .quo(d_quo), .rem(d_rem)
  );
endmodule

// File: rtl/pwm_freq_solver_chk.sv
module pwm_freq_solver_chk #(
  parameter int unsigned MAX_FREQ_HZ = 62_500_000,
  parameter int          FREQ_W      = 32,
  parameter int          DIV_W       = 8,
  parameter int          WRAP_W      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [FREQ_W-1:0] in_freq,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_err,
  input logic [DIV_W-1:0]  out_div,
  input logic [WRAP_W-1:0] out_wrap,
  input logic [FREQ_W-1:0] out_freq
);
  localparam int DW      = FREQ_W + WRAP_W + 2;
  localparam int LAT_MAX = 3 * (DW + 4) + 4;

  logic zero_q, over_q, busy_q;
  int   lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zero_q <= 1'b0;
      over_q <= 1'b0;
      busy_q <= 1'b0;
      lat_q  <= 0;
    end else begin
      if (in_valid && in_ready) begin
        zero_q <= (in_freq == '0);
        over_q <= (in_freq > FREQ_W'(MAX_FREQ_HZ));
        busy_q <= 1'b1;
        lat_q  <= 0;
      end else if (busy_q) begin
        if (out_valid) busy_q <= 1'b0;
        else lat_q <= lat_q + 1;
      end
    end
  end

  assert_ready_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_err) && $stable(out_div)
      && $stable(out_wrap) && $stable(out_freq));
  assert_zero_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && zero_q |-> out_err);
  assert_over_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && over_q |-> out_err);
  assert_ok_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> out_div != '0 && out_wrap != '0);
  assert_err_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && out_err |-> $stable(out_div) && $stable(out_wrap)
      && $stable(out_freq));
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q <= LAT_MAX);
endmodule

bind pwm_freq_solver pwm_freq_solver_chk #(
  .MAX_FREQ_HZ(MAX_FREQ_HZ), .FREQ_W(FREQ_W), .DIV_W(DIV_W), .WRAP_W(WRAP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_freq(in_freq), .out_valid(out_valid), .out_ready(out_ready),
  .out_err(out_err), .out_div(out_div), .out_wrap(out_wrap), .out_freq(out_freq)
);

// File: tb/pwm_freq_solver_test.sv
`timescale 1ns/1ps
module pwm_freq_solver_test;
  localparam longint unsigned CLK = 125_000_000;
  localparam longint unsigned MAXF = 62_500_000;
  localparam int LAT_MAX = 3 * (50 + 4) + 4;
  localparam int NV = 12;
  // {freq, expected error, expected prescaler}
  localparam logic [40:0] VEC [NV] = '{
    {32'd1000,       1'b0, 8'd2},
    {32'd62_500_000, 1'b0, 8'd1},
    {32'd62_500_001, 1'b1, 8'd0},
    {32'd0,          1'b1, 8'd0},
    {32'd7,          1'b1, 8'd0},
    {32'd8,          1'b0, 8'd239},
    {32'd50_000_000, 1'b0, 8'd1},
    {32'd1907,       1'b0, 8'd2},
    {32'd1908,       1'b0, 8'd1},
    {32'd440,        1'b0, 8'd5},
    {32'd20000,      1'b0, 8'd1},
    {32'd1,          1'b1, 8'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic a_iv = 0, a_ir, a_ov, a_or = 0, a_err;
  logic [31:0] a_if = 0, a_fq;
  logic [7:0] a_dv;
  logic [15:0] a_wr;
  logic b_iv = 0, b_ir, b_ov, b_or = 0, b_err;
  logic [31:0] b_if = 0, b_fq;
  logic [7:0] b_dv;
  logic [15:0] b_wr;

  int n_chk = 0, n_bad = 0;
  int last_lat;

  pwm_freq_solver uut (
    .clk(clk), .rst_n(rst_n), .in_valid(a_iv), .in_ready(a_ir), .in_freq(a_if),
    .out_valid(a_ov), .out_ready(a_or), .out_err(a_err), .out_div(a_dv),
    .out_wrap(a_wr), .out_freq(a_fq));

  pwm_freq_solver #(.MAX_FREQ_HZ(125_000_000)) uut_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(b_iv), .in_ready(b_ir), .in_freq(b_if),
    .out_valid(b_ov), .out_ready(b_or), .out_err(b_err), .out_div(b_dv),
    .out_wrap(b_wr), .out_freq(b_fq));

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model(input longint unsigned f, input longint unsigned maxf,
                                output bit e, output longint unsigned w, output longint unsigned a);
    longint unsigned d, p;
    e = 0; w = 0; a = 0;
    if (f == 0 || f > maxf) begin e = 1; return; end
    d = (CLK + f * 65536 - 1) / (f * 65536);
    if (d == 0) d = 1;
    if (d > 255) begin e = 1; return; end
    p = (2 * CLK + d * f) / (2 * d * f);
    if (p < 2) begin e = 1; return; end
    w = p - 1;
    a = CLK / (d * p);
  endfunction

  task automatic run(input bit sel, input logic [31:0] f, output logic e,
                     output logic [7:0] d, output logic [15:0] w, output logic [31:0] a);
    int n = 0;
    @(negedge clk);
    if (sel) begin b_iv = 1; b_if = f; end else begin a_iv = 1; a_if = f; end
    @(negedge clk);
    a_iv = 0; b_iv = 0;
    while (!(sel ? b_ov : a_ov) && n < 2000) begin @(negedge clk); n++; end
    last_lat = n;
    if (n >= 2000) check("R10 watchdog", 1, 0);
    e = sel ? b_err : a_err;
    d = sel ? b_dv : a_dv;
    w = sel ? b_wr : a_wr;
    a = sel ? b_fq : a_fq;
    if (sel) b_or = 1; else a_or = 1;
    @(negedge clk);
    a_or = 0; b_or = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    check("watchdog", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic e;
    logic [7:0] d;
    logic [15:0] w;
    logic [31:0] a;
    bit me;
    longint unsigned mw, ma;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 in_ready", a_ir, 1);
    check("R1 out_valid", a_ov, 0);
    check("R1 out_err", a_err, 0);
    check("R1 outputs", {a_dv, a_wr, a_fq}, 0);

    for (int i = 0; i < NV; i++) begin
      model(VEC[i][40:9], MAXF, me, mw, ma);
      run(0, VEC[i][40:9], e, d, w, a);
      check($sformatf("R2/R3/R4 err f=%0d", VEC[i][40:9]), e, VEC[i][8]);
      if (!VEC[i][8]) begin
        check($sformatf("R4 div f=%0d", VEC[i][40:9]), d, VEC[i][7:0]);
        check($sformatf("R5 wrap f=%0d", VEC[i][40:9]), w, mw);
        check($sformatf("R6 freq f=%0d", VEC[i][40:9]), a, ma);
      end
      check("R10 latency", (last_lat <= LAT_MAX), 1);
    end

    // R5/R6 hand-derived values
    run(0, 32'd8, e, d, w, a);
    check("R5 wrap 8Hz", w, 65376);
    check("R6 freq 8Hz", a, 7);
    run(0, 32'd50_000_000, e, d, w, a);
    check("R5 wrap 50MHz", w, 2);
    check("R6 freq 50MHz", a, 41666666);

    // R8 error keeps previous result
    run(0, 32'd1000, e, d, w, a);
    run(0, 32'd0, e, d, w, a);
    check("R8 err", e, 1);
    check("R8 div kept", d, 2);
    check("R8 wrap kept", w, 62499);
    check("R8 freq kept", a, 1000);
    run(0, 32'd7, e, d, w, a);
    check("R8 wrap kept after R4 err", w, 62499);

    // R9 back-pressure
    @(negedge clk); a_iv = 1; a_if = 32'd440;
    @(negedge clk); a_iv = 0;
    while (!a_ov) @(negedge clk);
    d = a_dv; w = a_wr; a = a_fq;
    repeat (5) @(negedge clk);
    check("R9 valid held", a_ov, 1);
    check("R9 in_ready low", a_ir, 0);
    check("R9 fields stable", {a_dv, a_wr, a_fq}, {d, w, a});
    a_or = 1; @(negedge clk); a_or = 0;
    check("R9 released", {a_ov, a_ir}, 2'b01);

    // R7 on wide instance
    run(1, 32'd100_000_000, e, d, w, a);
    check("R7 err 100MHz", e, 1);
    run(1, 32'd125_000_000, e, d, w, a);
    check("R7 err 125MHz", e, 1);
    run(1, 32'd80_000_000, e, d, w, a);
    check("R7 ok 80MHz", e, 0);
    check("R5 wrap 80MHz", w, 1);
    check("R6 freq 80MHz", a, 62500000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule